// File: doc/BRIEF.md
# Prioritized Local-to-PCI Address Window Translator

This block turns a local-bus address into a PCI bus address. It holds three programmable windows. Each window has a start register and a target register. Windows 0 and 1 are memory windows with a programmable size from 1 MB to 2 GB. Window 2 is a fixed 16 MB I/O window. For every address it accepts, the block looks at each enabled window and picks the lowest-numbered window that covers the address. Windows may overlap, so growing window 0 can hide window 1 completely. The result is the translated address, a 3-bit PCI cycle type, an address-low passthrough flag and a hit flag.

Addresses arrive on a valid/ready request channel, and results leave on a valid/ready response channel one cycle after acceptance. The output holds one entry. A request is accepted when `req_valid` and `req_ready` are both high, and `req_ready` is high whenever the output stage is empty or is being drained in the same cycle. A sender must keep `req_valid` and `req_addr` steady until the request is accepted. The response stays frozen while `rsp_valid` is high and `rsp_ready` is low. Window registers are written through a plain select/data write port. The translation of a request uses the register contents in force in the cycle the request is accepted.

Top module: `awt_xlate`

## Requirements
- R1: After reset `rsp_valid` is low, `req_ready` is high and every window is disabled, so the first translation is a miss.
- R2: A request accepted at a clock edge shows up on the response port after that edge with `rsp_valid` high. `req_ready` equals `!rsp_valid || rsp_ready`. A response that is not taken holds all its fields stable. A response that is taken with no new request accepted leaves `rsp_valid` low.
- R3: The write port decodes `cfg_sel` as follows: 0 is the window 0 start register, 1 is the window 0 target register, 2 is the window 1 start register, 3 is the window 1 target register, 4 is the I/O start register and 5 is the I/O target register. Writes to 6 and 7 change nothing. Target registers and the I/O start register take `cfg_wdata[15:0]`. A write affects only requests accepted in later cycles.
- R4: In a memory window start register, bits 31:20 give the start and bit 0 enables the window. Bits 7:4 hold a size code n that gives a size of 1 MB << n. Codes 12 to 15 act as code 11 (2 GB). Bit 3, the prefetch mark, has no effect on translation. Only address bits at or above 20+n are compared, so start bits below the size are ignored.
- R5: On a memory window hit, the output takes its bits at or above 20+n from target bits 15:4, which are placed at address bits 31:20. Bits below 20+n come from the input address. `rsp_ctype` equals target bits 3:1 and `rsp_adlow` equals target bit 0.
- R6: The I/O window is enabled by start bit 0. It hits when address bits 31:24 equal start bits 15:8. Its output is {target bits 15:8, address bits 23:0}, with `rsp_ctype` = 1 (I/O) and `rsp_adlow` = 0.
- R7: When more than one enabled window matches, window 0 wins over window 1, and window 1 wins over the I/O window.
- R8: When no enabled window matches, `rsp_hit` is 0 and `rsp_addr`, `rsp_ctype` and `rsp_adlow` are all 0.
- R9: Every cycle-type code passes through unchanged: 0 interrupt acknowledge, 1 I/O, 3 memory, 5 configuration and 6 memory-multiple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Request may be accepted |
| req_addr | input | 32 | Local-bus address |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_addr | output | 32 | Translated PCI address, 0 on miss |
| rsp_hit | output | 1 | Some enabled window matched |
| rsp_ctype | output | 3 | PCI cycle type of the winning window |
| rsp_adlow | output | 1 | Address-low passthrough flag |

## Verification
The hardest case to reach is the one where overlapping windows decide the winner while the response port is stalled. In that case a held result must keep the translation of the old request, even though the winning window's registers have since been rewritten. The directed phases reach the overlap on purpose. Window 0 is grown to 512 MB so that it covers window 1. The I/O window is placed inside a memory window. Each size code from 0 to 15 is walked with addresses just inside and just outside the window. A final phase sends a random stream with random back-pressure into overlapping windows. The bench model holds the expected result through every stall and compares it with the outputs on every clock.

// File: rtl/awt_pkg.sv
package awt_pkg;
  localparam int ADDR_W        = 32;
  localparam int PAGE_LSB      = 20;
  localparam int MAX_SIZE_CODE = 11;
  localparam int IO_LSB        = 24;
  localparam int PAGE_W        = ADDR_W - PAGE_LSB;
  localparam int IO_W          = ADDR_W - IO_LSB;
  localparam int SH_W          = $clog2(ADDR_W);

  typedef enum logic [2:0] {
    CT_IACK    = 3'd0,
    CT_IO      = 3'd1,
    CT_MEM     = 3'd3,
    CT_CFG     = 3'd5,
    CT_MEMMULT = 3'd6
  } cyc_type_e;

  typedef struct packed {
    logic [PAGE_W-1:0] start;
    logic [3:0]        size_code;
    logic              en;
  } mem_base_t;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [2:0]        ctype;
    logic              adlow;
  } mem_map_t;

  typedef struct packed {
    logic [IO_W-1:0] start;
    logic            en;
  } io_base_t;

  typedef struct packed {
    logic [IO_W-1:0] page;
  } io_map_t;

  typedef struct packed {
    logic              hit;
    logic [ADDR_W-1:0] addr;
    logic [2:0]        ctype;
    logic              adlow;
  } xl_t;
endpackage

// File: rtl/awt_regs.sv
module awt_regs
  import awt_pkg::*;
#(
  parameter int NUM_MEM_WIN = 2,
  parameter int DATA_W      = 32,
  localparam int SEL_W      = $clog2(2 * (NUM_MEM_WIN + 1))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output mem_base_t         mem_base [NUM_MEM_WIN],
  output mem_map_t          mem_map  [NUM_MEM_WIN],
  output io_base_t          io_base,
  output io_map_t           io_map
);
  localparam int IO_SEL = 2 * NUM_MEM_WIN;

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata[PAGE_LSB-1:16];

  for (genvar w = 0; w < NUM_MEM_WIN; w++) begin : g_mem
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_base[w] <= '0;
        mem_map[w]  <= '0;
      end else if (cfg_we) begin
        if (cfg_sel == SEL_W'(2 * w)) begin
          mem_base[w].start     <= cfg_wdata[ADDR_W-1:PAGE_LSB];
          mem_base[w].size_code <= cfg_wdata[7:4];
          mem_base[w].en        <= cfg_wdata[0];
        end
        if (cfg_sel == SEL_W'(2 * w + 1)) begin
          mem_map[w] <= cfg_wdata[15:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_base <= '0;
      io_map  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_W'(IO_SEL)) begin
        io_base.start <= cfg_wdata[15:8];
        io_base.en    <= cfg_wdata[0];
      end
      if (cfg_sel == SEL_W'(IO_SEL + 1)) begin
        io_map.page <= cfg_wdata[15:8];
      end
    end
  end
endmodule

// File: rtl/awt_mem_win.sv
module awt_mem_win
  import awt_pkg::*;
(
  input  mem_base_t         base,
  input  mem_map_t          map,
  input  logic [ADDR_W-1:0] addr,
  output xl_t               res
);
  logic [3:0]        code;
  logic [SH_W-1:0]   sh;
  logic [ADDR_W-1:0] hi_mask;
  logic [ADDR_W-1:0] start_full;
  logic [ADDR_W-1:0] page_full;
  logic              match;

  always_comb begin
    code       = (base.size_code > 4'(MAX_SIZE_CODE)) ? 4'(MAX_SIZE_CODE) : base.size_code;
    sh         = SH_W'(PAGE_LSB) + SH_W'(code);
    hi_mask    = {ADDR_W{1'b1}} << sh;
    start_full = {base.start, {PAGE_LSB{1'b0}}};
    page_full  = {map.page,   {PAGE_LSB{1'b0}}};
    match      = base.en && (((addr ^ start_full) & hi_mask) == '0);
    res        = '0;
    if (match) begin
      res.hit   = 1'b1;
      res.addr  = (page_full & hi_mask) | (addr & ~hi_mask);
      res.ctype = map.ctype;
      res.adlow = map.adlow;
    end
  end
endmodule

// File: rtl/awt_io_win.sv
module awt_io_win
  import awt_pkg::*;
(
  input  io_base_t          base,
  input  io_map_t           map,
  input  logic [ADDR_W-1:0] addr,
  output xl_t               res
);
  always_comb begin
    res = '0;
    if (base.en && addr[ADDR_W-1:IO_LSB] == base.start) begin
      res.hit   = 1'b1;
      res.addr  = {map.page, addr[IO_LSB-1:0]};
      res.ctype = CT_IO;
      res.adlow = 1'b0;
    end
  end
endmodule

// File: rtl/awt_xlate.sv
module awt_xlate
  import awt_pkg::*;
#(
  parameter int NUM_MEM_WIN = 2,
  parameter int DATA_W      = 32,
  localparam int NUM_WIN    = NUM_MEM_WIN + 1,
  localparam int SEL_W      = $clog2(2 * NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_hit,
  output logic [2:0]        rsp_ctype,
  output logic              rsp_adlow
);
  mem_base_t mem_base [NUM_MEM_WIN];
  mem_map_t  mem_map  [NUM_MEM_WIN];
  io_base_t  io_base;
  io_map_t   io_map;
  xl_t       cand [NUM_WIN];
  xl_t       win_res;
  xl_t       res_q;

  awt_regs #(.NUM_MEM_WIN(NUM_MEM_WIN), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mem_base(mem_base), .mem_map(mem_map),
    .io_base(io_base), .io_map(io_map)
  );

  for (genvar w = 0; w < NUM_MEM_WIN; w++) begin : g_win
    awt_mem_win u_win (
      .base(mem_base[w]), .map(mem_map[w]), .addr(req_addr), .res(cand[w])
    );
  end

  awt_io_win u_io (
    .base(io_base), .map(io_map), .addr(req_addr), .res(cand[NUM_MEM_WIN])
  );

  // Scan from the highest index down so the lowest matching window is kept.
  always_comb begin
    win_res = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (cand[w].hit) win_res = cand[w];
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      res_q     <= '0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      res_q     <= win_res;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_addr  = res_q.addr;
  assign rsp_hit   = res_q.hit;
  assign rsp_ctype = res_q.ctype;
  assign rsp_adlow = res_q.adlow;
endmodule

// File: rtl/awt_xlate_chk.sv
module awt_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_addr,
  input logic        rsp_hit,
  input logic [2:0]  rsp_ctype,
  input logic        rsp_adlow
);
  logic [31:0] acc_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_addr <= '0;
    else if (req_valid && req_ready) acc_addr <= req_addr;
  end

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_addr == '0 && rsp_ctype == '0 && !rsp_adlow);

  p_ready_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> rsp_valid && !rsp_ready);

  p_accept_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_hit)
      && $stable(rsp_ctype) && $stable(rsp_adlow));

  p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && !req_valid |=> !rsp_valid);

  // R5 and R6: every hit keeps at least the lowest 20 offset bits.
  p_offset_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> rsp_addr[19:0] == acc_addr[19:0]);
endmodule

bind awt_xlate awt_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_addr(rsp_addr), .rsp_hit(rsp_hit), .rsp_ctype(rsp_ctype),
  .rsp_adlow(rsp_adlow)
);

// File: tb/awt_xlate_test.sv
`timescale 1ns/1ps
module awt_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic        rsp_hit;
  logic [2:0]  rsp_ctype;
  logic        rsp_adlow;

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  awt_xlate uut (.*);

  // Reference model state
  logic [31:0] m_base [2];
  logic [15:0] m_map [2];
  logic [15:0] m_iob, m_iom;
  bit          m_valid = 0;
  bit          m_hit, m_adl, last_acc;
  logic [31:0] m_addr;
  logic [2:0]  m_ct;

  function automatic void predict(input logic [31:0] a, output bit h,
                                  output logic [31:0] xa, output logic [2:0] ct,
                                  output bit adl);
    h = 0; xa = '0; ct = '0; adl = 0;
    for (int w = 0; w < 2; w++) begin
      if (!h && m_base[w][0]) begin
        int n = int'(m_base[w][7:4]);
        int sh;
        logic [31:0] low;
        if (n > 11) n = 11;
        sh = 20 + n;
        if ((a >> sh) == (m_base[w] >> sh)) begin
          low = (32'h1 << sh) - 32'h1;
          h = 1;
          xa = ({m_map[w][15:4], 20'h0} & ~low) | (a & low);
          ct = m_map[w][3:1];
          adl = m_map[w][0];
        end
      end
    end
    if (!h && m_iob[0] && a[31:24] == m_iob[15:8]) begin
      h = 1; xa = {m_iom[15:8], a[23:0]}; ct = 3'd1; adl = 0;
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; last_acc = 0;
      m_base[0] = '0; m_base[1] = '0; m_map[0] = '0; m_map[1] = '0;
      m_iob = '0; m_iom = '0;
    end else begin
      last_acc = req_valid && (!m_valid || rsp_ready);
      if (last_acc) begin
        predict(req_addr, m_hit, m_addr, m_ct, m_adl);
        m_valid = 1;
      end else if (rsp_ready) begin
        m_valid = 0;
      end
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: m_base[0] = cfg_wdata;
          3'd1: m_map[0]  = cfg_wdata[15:0];
          3'd2: m_base[1] = cfg_wdata;
          3'd3: m_map[1]  = cfg_wdata[15:0];
          3'd4: m_iob     = cfg_wdata[15:0];
          3'd5: m_iom     = cfg_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("rsp_valid", 32'(rsp_valid), 32'(m_valid));
      compared++;
      if (req_ready !== (!m_valid || rsp_ready)) begin
        mismatched++;
        $display("FAIL R2 req_ready: got %b expected %b", req_ready, !m_valid || rsp_ready);
      end
      if (m_valid) begin
        chk("rsp_hit", 32'(rsp_hit), 32'(m_hit));
        chk("rsp_addr", rsp_addr, m_addr);
        chk("rsp_ctype", 32'(rsp_ctype), 32'(m_ct));
        chk("rsp_adlow", 32'(rsp_adlow), 32'(m_adl));
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic send(input logic [31:0] a);
    req_valid = 1; req_addr = a;
    tick();
    req_valid = 0;
    tick();
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    compared++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      mismatched++;
      $display("FAIL R1 reset: got valid=%b ready=%b expected 0/1", rsp_valid, req_ready);
    end
    rst_n = 1; tick();
    tag = "R1"; send(32'h4000_0000); send(32'h6000_0000);

    // R4/R5: 256 MB window 0, memory type
    tag = "R5";
    wr(3'd0, 32'h4000_0081); wr(3'd1, 32'h2006);
    send(32'h4000_0000); send(32'h4FFF_FFFC); send(32'h4123_4567);
    tag = "R8"; send(32'h5000_0000); send(32'h3FFF_FFFF);
    tag = "R4"; wr(3'd0, 32'h4567_0089);
    send(32'h4123_4567); send(32'h4FAB_CDEF);

    // R4: walk all size codes on window 1
    wr(3'd0, 32'h0);
    wr(3'd3, 32'hA006);
    for (int n = 0; n < 16; n++) begin
      int e = (n > 11) ? 11 : n;
      longint sz = longint'(1) << (20 + e);
      tag = "R4";
      wr(3'd2, 32'h8000_0001 | (n << 4));
      send(32'h8000_0000);
      send(32'(64'h8000_0000 + sz - 1));
      if (e < 11) send(32'(64'h8000_0000 + sz));
      send(32'h7FFF_FFFF);
    end

    // R6: I/O window
    tag = "R6";
    wr(3'd2, 32'h0);
    wr(3'd4, 32'h0000_6001); wr(3'd5, 32'h0000_1200);
    send(32'h60AB_CDEF); send(32'h6000_0000); send(32'h61FF_FFFF);

    // R8: disabled window with matching start misses
    tag = "R8";
    wr(3'd4, 32'h0000_6000); send(32'h60AB_CDEF);

    // R7: overlapping windows
    tag = "R7";
    wr(3'd0, 32'h4000_0091); wr(3'd1, 32'h3007);
    wr(3'd2, 32'h5000_0081); wr(3'd3, 32'hB00B);
    wr(3'd4, 32'h0000_5201); wr(3'd5, 32'h0000_7700);
    send(32'h5200_1234); send(32'h5FFF_0000);
    wr(3'd0, 32'h4000_0081);
    send(32'h5200_1234); send(32'h5300_0004); send(32'h4800_0000);
    wr(3'd2, 32'h0); send(32'h5200_1234);

    // R9: every cycle-type code with adlow set
    tag = "R9";
    wr(3'd0, 32'h4000_0081);
    for (int c = 0; c < 8; c++) begin
      wr(3'd1, 32'h2000 | (c << 1) | 1);
      send(32'h4000_0100 + c);
    end

    // R3: unused selects and upper data bits are ignored; same-cycle write
    tag = "R3";
    wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'h0000_0000);
    send(32'h4000_0200);
    wr(3'd1, 32'hFFFF_300A); send(32'h4000_0300);
    cfg_we = 1; cfg_sel = 3'd1; cfg_wdata = 32'h5006;
    req_valid = 1; req_addr = 32'h4000_0400;
    tick();
    cfg_we = 0; req_valid = 0; tick();
    send(32'h4000_0400);

    // R2: random stream with back-pressure over overlapping windows
    tag = "R2";
    wr(3'd0, 32'h4000_0071); wr(3'd1, 32'h100B);
    wr(3'd2, 32'h4400_0061); wr(3'd3, 32'h880A);
    wr(3'd4, 32'h0000_4501); wr(3'd5, 32'h0000_9900);
    for (int i = 0; i < 4000; i++) begin
      if (!req_valid || last_acc) begin
        req_valid = ($urandom % 4) != 0;
        req_addr = {4'h4, 4'($urandom % 8), 24'($urandom)};
      end
      rsp_ready = ($urandom % 3) != 0;
      if (i % 500 == 250 && !req_valid) wr(3'd1, 32'($urandom % 65536));
      else tick();
    end
    req_valid = 0; rsp_ready = 1;
    repeat (3) tick();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule